// File: doc/BRIEF.md
# Paged Address Translation Unit

The unit turns 8-bit logical word addresses into physical word addresses for a 256-word memory divided into 8-word pages. The upper five address bits select a page and the low three bits are the offset within it. A mapping table with one entry for each of the 32 pages supplies a frame number, a valid flag and a modify flag. Every reference, including instruction fetches, is first compared with a limit. It is then either translated, refused as out of bounds, or refused as a page fault. The unit returns a status-register image that tells the operating system which page must be brought in.

At each context switch the table is replaced as a whole. A short start pulse is followed by a valid/ready stream of 32 entries in page order. Requests arrive on a valid/ready channel and are handled one at a time. The response is held on a second valid/ready channel until the consumer takes it. While a request is in flight or a load is running, `req_ready_o` stays low, which is how back-pressure reaches the requester. A response that is not taken keeps every response field frozen. A plain readback port exposes any table entry, so the modify flags can be inspected before a page is evicted.

Entry packing, used by both the load stream and the readback port: bit 6 is modify, bit 5 is valid, bits 4:0 are the frame.

Top module: `pat_top`

## Requirements
- R1: After reset, `rsp_valid_o` is 0, `req_ready_o` is 1, `ld_ready_o` is 0, and every table entry reads back as 0 (invalid, unmodified, frame 0).
- R2: A `ld_start_i` pulse while idle starts a load. `ld_ready_o` is then 1 and `req_ready_o` is 0 until 32 entries have been taken, one per cycle in which `ld_valid_i` is 1, and they are written to pages 0 to 31 in order. Cycles in which `ld_valid_i` is 0 are skipped without writing.
- R3: A reference whose address is greater than `limit_i` (sampled with the request) gets status 2 whatever its entry holds. It returns `rsp_sr_o` with bits 7:5 = 100 and all other bits 0, and `rsp_paddr_o` = 0. Its response is valid one cycle after acceptance.
- R4: An in-bound reference to a page whose valid flag is 0 gets status 1 (page fault). It returns `rsp_sr_o` with bits 15:11 = page number, bit 10 = 1 and all other bits 0, including bits 7:5 = 000. `rsp_paddr_o` is 0 and the response is valid one cycle after acceptance.
- R5: An in-bound reference to a valid page gets status 0. It returns `rsp_paddr_o` = {frame, address bits 2:0}, with `rsp_sr_o` = 0 and so bit 10 = 0. Its response is valid exactly 4 cycles after acceptance.
- R6: A status-0 write sets the modify flag of the accessed entry. Reads, faulting writes and out-of-bounds writes leave every modify flag unchanged.
- R7: Only one request is outstanding at a time. `req_ready_o` is 0 from acceptance until the response is taken, and the response fields stay stable while `rsp_valid_o` is 1 and `rsp_ready_i` is 0.
- R8: `tbl_entry_o` shows the entry selected by `tbl_idx_i` one cycle after `tbl_idx_i` is applied.
- R9: A new load replaces every field of every entry, modify flags included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| limit_i | input | 8 | Highest legal logical address, captured with each request |
| ld_start_i | input | 1 | Starts a table load (acts only while idle) |
| ld_valid_i | input | 1 | Load stream entry valid |
| ld_ready_o | output | 1 | Load stream ready |
| ld_entry_i | input | 7 | Load entry {modify, valid, frame} |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Translation request ready |
| req_addr_i | input | 8 | Logical address |
| req_write_i | input | 1 | 1 for a write reference |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_paddr_o | output | 8 | Physical address |
| rsp_status_o | output | 2 | 0 hit, 1 page fault, 2 out of bounds |
| rsp_sr_o | output | 16 | Status-register image |
| tbl_idx_i | input | 5 | Readback page select |
| tbl_entry_o | output | 7 | Readback entry {modify, valid, frame} |

## Verification
A wrong table entry shows up on the very next reference to that page, as a wrong frame in the physical address or a fault where a hit was due. A wrong modify flag is invisible to translation and appears only on the readback port one cycle after the page is selected. Control faults in the handshake or the latency counter show up on the first request as a response arriving in the wrong cycle, a response that changes under back-pressure, or a ready that never returns. Sweeping every address under two table patterns and several limits reaches each page, each offset and the bounds edge.

// File: rtl/pat_pkg.sv
package pat_pkg;
  typedef enum logic [1:0] {
    XS_HIT    = 2'd0,
    XS_FAULT  = 2'd1,
    XS_BOUNDS = 2'd2
  } xs_status_e;

  localparam int SR_W      = 16;
  localparam int SR_PF_BIT = 10;
  localparam int SR_RET_LO = 5;
  localparam int SR_RET_W  = 3;
  localparam logic [SR_RET_W-1:0] RET_BOUNDS = 3'b100;
endpackage

// File: rtl/pat_table.sv
module pat_table #(
  parameter int PAGE_W = 5,
  localparam int ENT_W = PAGE_W + 2,
  localparam int NPAGE = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [PAGE_W-1:0] ld_idx,
  input  logic [ENT_W-1:0]  ld_ent,
  input  logic              mod_set,
  input  logic [PAGE_W-1:0] mod_idx,
  input  logic [PAGE_W-1:0] lk_idx,
  output logic              lk_valid,
  output logic [PAGE_W-1:0] lk_frame,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [ENT_W-1:0]  rd_ent
);
  logic [ENT_W-1:0] ent [NPAGE];

  for (genvar g = 0; g < NPAGE; g++) begin : g_ent
    logic [ENT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld_we && ld_idx == PAGE_W'(g)) begin
        q <= ld_ent;
      end else if (mod_set && mod_idx == PAGE_W'(g)) begin
        q[ENT_W-1] <= 1'b1;
      end
    end
    assign ent[g] = q;
  end

  logic [ENT_W-1:0] lk_ent;
  assign lk_ent   = ent[lk_idx];
  assign lk_valid = lk_ent[ENT_W-2];
  assign lk_frame = lk_ent[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_ent <= '0;
    else        rd_ent <= ent[rd_idx];
  end
endmodule

// File: rtl/pat_check.sv
module pat_check
  import pat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFFS_W = 3,
  localparam int PAGE_W = ADDR_W - OFFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] limit,
  input  logic              ent_valid,
  input  logic [PAGE_W-1:0] ent_frame,
  output xs_status_e        status,
  output logic [ADDR_W-1:0] paddr,
  output logic [SR_W-1:0]   sr
);
  logic [PAGE_W-1:0] page;
  assign page = addr[ADDR_W-1:OFFS_W];

  always_comb begin
    sr    = '0;
    paddr = '0;
    if (addr > limit) begin
      status = XS_BOUNDS;
      sr[SR_RET_LO +: SR_RET_W] = RET_BOUNDS;
    end else if (!ent_valid) begin
      status = XS_FAULT;
      sr[SR_PF_BIT] = 1'b1;
      sr[SR_W-1 -: PAGE_W] = page;
    end else begin
      status = XS_HIT;
      paddr  = {ent_frame, addr[OFFS_W-1:0]};
    end
  end
endmodule

// File: rtl/pat_ctrl.sv
module pat_ctrl
  import pat_pkg::*;
#(
  parameter int PAGE_W  = 5,
  parameter int HIT_LAT = 4,
  localparam int CNT_W  = $clog2(HIT_LAT + 1),
  localparam int NPAGE  = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_start_i,
  input  logic              ld_valid_i,
  input  logic              req_valid_i,
  input  logic              rsp_ready_i,
  input  xs_status_e        eval_status,
  output logic              ld_ready_o,
  output logic              ld_we_o,
  output logic [PAGE_W-1:0] ld_idx_o,
  output logic              req_ready_o,
  output logic              accept_o,
  output logic              eval_o,
  output logic              rsp_valid_o
);
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_EVAL, S_WAIT, S_RESP
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;

  assign req_ready_o = (state == S_IDLE) && !ld_start_i;
  assign accept_o    = req_ready_o && req_valid_i;
  assign ld_ready_o  = (state == S_LOAD);
  assign ld_we_o     = ld_ready_o && ld_valid_i;
  assign eval_o      = (state == S_EVAL);
  assign rsp_valid_o = (state == S_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ld_idx_o <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ld_start_i) begin
            state    <= S_LOAD;
            ld_idx_o <= '0;
          end else if (req_valid_i) begin
            state <= S_EVAL;
          end
        end
        S_LOAD: begin
          if (ld_valid_i) begin
            ld_idx_o <= ld_idx_o + 1'b1;
            if (ld_idx_o == PAGE_W'(NPAGE - 1)) state <= S_IDLE;
          end
        end
        S_EVAL: begin
          if (eval_status != XS_HIT) begin
            state <= S_RESP;
          end else begin
            state <= S_WAIT;
            cnt   <= CNT_W'(HIT_LAT - 2);
          end
        end
        S_WAIT: begin
          if (cnt == '0) state <= S_RESP;
          else           cnt   <= cnt - 1'b1;
        end
        S_RESP: begin
          if (rsp_ready_i) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pat_top.sv
module pat_top
  import pat_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int OFFS_W  = 3,
  parameter int HIT_LAT = 4,
  localparam int PAGE_W = ADDR_W - OFFS_W,
  localparam int ENT_W  = PAGE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              ld_start_i,
  input  logic              ld_valid_i,
  output logic              ld_ready_o,
  input  logic [ENT_W-1:0]  ld_entry_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [1:0]        rsp_status_o,
  output logic [SR_W-1:0]   rsp_sr_o,
  input  logic [PAGE_W-1:0] tbl_idx_i,
  output logic [ENT_W-1:0]  tbl_entry_o
);
  logic              accept, eval, ld_we;
  logic [PAGE_W-1:0] ld_idx;
  logic [ADDR_W-1:0] cap_addr, cap_limit;
  logic              cap_write;
  logic              lk_valid;
  logic [PAGE_W-1:0] lk_frame;
  xs_status_e        chk_status;
  logic [ADDR_W-1:0] chk_paddr;
  logic [SR_W-1:0]   chk_sr;
  logic              mod_set;

  pat_ctrl #(.PAGE_W(PAGE_W), .HIT_LAT(HIT_LAT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_start_i  (ld_start_i),
    .ld_valid_i  (ld_valid_i),
    .req_valid_i (req_valid_i),
    .rsp_ready_i (rsp_ready_i),
    .eval_status (chk_status),
    .ld_ready_o  (ld_ready_o),
    .ld_we_o     (ld_we),
    .ld_idx_o    (ld_idx),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .eval_o      (eval),
    .rsp_valid_o (rsp_valid_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_limit <= '0;
      cap_write <= 1'b0;
    end else if (accept) begin
      cap_addr  <= req_addr_i;
      cap_limit <= limit_i;
      cap_write <= req_write_i;
    end
  end

  assign mod_set = eval && cap_write && (chk_status == XS_HIT);

  pat_table #(.PAGE_W(PAGE_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_we    (ld_we),
    .ld_idx   (ld_idx),
    .ld_ent   (ld_entry_i),
    .mod_set  (mod_set),
    .mod_idx  (cap_addr[ADDR_W-1:OFFS_W]),
    .lk_idx   (cap_addr[ADDR_W-1:OFFS_W]),
    .lk_valid (lk_valid),
    .lk_frame (lk_frame),
    .rd_idx   (tbl_idx_i),
    .rd_ent   (tbl_entry_o)
  );

  pat_check #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_check (
    .addr      (cap_addr),
    .limit     (cap_limit),
    .ent_valid (lk_valid),
    .ent_frame (lk_frame),
    .status    (chk_status),
    .paddr     (chk_paddr),
    .sr        (chk_sr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_paddr_o  <= '0;
      rsp_status_o <= '0;
      rsp_sr_o     <= '0;
    end else if (eval) begin
      rsp_paddr_o  <= chk_paddr;
      rsp_status_o <= chk_status;
      rsp_sr_o     <= chk_sr;
    end
  end
endmodule

// File: rtl/pat_sva.sv
module pat_sva
  import pat_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int OFFS_W  = 3,
  parameter int HIT_LAT = 4,
  localparam int PAGE_W = ADDR_W - OFFS_W,
  localparam int CW     = $clog2(HIT_LAT + 2) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] limit_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              ld_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic [1:0]        rsp_status_o,
  input logic [SR_W-1:0]   rsp_sr_o
);
  logic [ADDR_W-1:0] acc_addr, acc_limit;
  logic [CW-1:0]     lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_addr  <= '0;
      acc_limit <= '0;
      lat_cnt   <= '0;
    end else if (req_valid_i && req_ready_o) begin
      acc_addr  <= req_addr_i;
      acc_limit <= limit_i;
      lat_cnt   <= '0;
    end else if (lat_cnt != {CW{1'b1}}) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  // R7
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready_o && rsp_valid_o));

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o)
      && $stable(rsp_status_o) && $stable(rsp_sr_o));

  // R2
  load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_ready_o && req_ready_o));

  // R4
  fault_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_status_o == 2'd1 |->
      rsp_sr_o[SR_PF_BIT] && rsp_sr_o[SR_RET_LO +: SR_RET_W] == '0
      && rsp_sr_o[SR_W-1 -: PAGE_W] == acc_addr[ADDR_W-1:OFFS_W]);

  // R5
  hit_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_status_o == 2'd0 |->
      rsp_sr_o == '0 && rsp_paddr_o[OFFS_W-1:0] == acc_addr[OFFS_W-1:0]);

  // R3
  bounds_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_status_o == 2'd2 |-> acc_addr > acc_limit);

  // R5
  hit_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid_o) && rsp_status_o == 2'd0 |-> lat_cnt == CW'(HIT_LAT));

  // R4
  early_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid_o) && rsp_status_o != 2'd0 |-> lat_cnt == CW'(1));
endmodule

bind pat_top pat_sva #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .HIT_LAT(HIT_LAT)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .limit_i      (limit_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_addr_i   (req_addr_i),
  .ld_ready_o   (ld_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_status_o (rsp_status_o),
  .rsp_sr_o     (rsp_sr_o)
);

// File: tb/pat_top_tb_top.sv
`timescale 1ns/1ps
module pat_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] limit_i = '0;
  logic       ld_start_i = 1'b0, ld_valid_i = 1'b0;
  logic       ld_ready_o;
  logic [6:0] ld_entry_i = '0;
  logic       req_valid_i = 1'b0, req_write_i = 1'b0;
  logic       req_ready_o;
  logic [7:0] req_addr_i = '0;
  logic       rsp_valid_o;
  logic       rsp_ready_i = 1'b0;
  logic [7:0] rsp_paddr_o;
  logic [1:0] rsp_status_o;
  logic [15:0] rsp_sr_o;
  logic [4:0] tbl_idx_i = '0;
  logic [6:0] tbl_entry_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  bit         sv [32];
  logic [4:0] sf [32];
  bit         sm [32];

  always #4 clk = ~clk;

  pat_top dut_i (
    .clk(clk), .rst_n(rst_n), .limit_i(limit_i),
    .ld_start_i(ld_start_i), .ld_valid_i(ld_valid_i), .ld_ready_o(ld_ready_o),
    .ld_entry_i(ld_entry_i), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i), .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i), .rsp_paddr_o(rsp_paddr_o), .rsp_status_o(rsp_status_o),
    .rsp_sr_o(rsp_sr_o), .tbl_idx_i(tbl_idx_i), .tbl_entry_o(tbl_entry_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] pack(input int p);
    return {sm[p], sv[p], sf[p]};
  endfunction

  function automatic void set_pattern(input int pat);
    for (int p = 0; p < 32; p++) begin
      if (pat == 0) begin
        sv[p] = (p % 3) != 0;
        sf[p] = 5'((p * 7 + 3) % 32);
        sm[p] = 1'b0;
      end else begin
        sv[p] = (p % 2) == 0;
        sf[p] = 5'(31 - p);
        sm[p] = (p % 4) == 0;
      end
    end
  endfunction

  task automatic load_tbl(input int pat, input bit gaps);
    set_pattern(pat);
    @(negedge clk); ld_start_i = 1'b1;
    @(posedge clk);
    @(negedge clk); ld_start_i = 1'b0;
    chk("R2 ld_ready during load", 32'(ld_ready_o), 32'd1);
    chk("R2 req_ready during load", 32'(req_ready_o), 32'd0);
    for (int p = 0; p < 32; p++) begin
      if (gaps && (p % 2) == 1) begin
        ld_valid_i = 1'b0; ld_entry_i = 7'h7f;
        @(posedge clk); @(negedge clk);
      end
      ld_valid_i = 1'b1; ld_entry_i = pack(p);
      @(posedge clk); @(negedge clk);
    end
    ld_valid_i = 1'b0;
    chk("R2 ld_ready after load", 32'(ld_ready_o), 32'd0);
    chk("R2 req_ready after load", 32'(req_ready_o), 32'd1);
  endtask

  task automatic rd_entry(input int p, input string tag);
    @(negedge clk); tbl_idx_i = 5'(p);
    @(posedge clk);
    @(negedge clk);
    chk(tag, 32'(tbl_entry_o), 32'(pack(p)));
  endtask

  task automatic do_req(input logic [7:0] a, input bit wr, input logic [7:0] lim, input int hold);
    int pg;
    int lat;
    logic [1:0]  est;
    logic [15:0] esr;
    logic [7:0]  epa;
    logic [7:0]  pa0;
    logic [15:0] sr0;
    logic [1:0]  st0;
    pg = int'(a >> 3);
    if (a > lim) begin
      est = 2'd2; esr = 16'h0080; epa = 8'h00;
    end else if (!sv[pg]) begin
      est = 2'd1; esr = 16'((pg << 11) | 32'h0400); epa = 8'h00;
    end else begin
      est = 2'd0; esr = 16'h0000; epa = {sf[pg], a[2:0]};
    end
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = wr; limit_i = lim;
    chk("R7 req_ready idle", 32'(req_ready_o), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!rsp_valid_o && lat < 20);
    if (est == 2'd2) begin
      chk("R3 status", 32'(rsp_status_o), 32'(est));
      chk("R3 sr", 32'(rsp_sr_o), 32'(esr));
      chk("R3 paddr", 32'(rsp_paddr_o), 32'(epa));
      chk("R3 latency", 32'(lat), 32'd1);
    end else if (est == 2'd1) begin
      chk("R4 status", 32'(rsp_status_o), 32'(est));
      chk("R4 sr", 32'(rsp_sr_o), 32'(esr));
      chk("R4 paddr", 32'(rsp_paddr_o), 32'(epa));
      chk("R4 latency", 32'(lat), 32'd1);
    end else begin
      chk("R5 status", 32'(rsp_status_o), 32'(est));
      chk("R5 sr", 32'(rsp_sr_o), 32'(esr));
      chk("R5 paddr", 32'(rsp_paddr_o), 32'(epa));
      chk("R5 latency", 32'(lat), 32'd4);
    end
    chk("R7 req_ready while pending", 32'(req_ready_o), 32'd0);
    pa0 = rsp_paddr_o; sr0 = rsp_sr_o; st0 = rsp_status_o;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk("R7 held valid", 32'(rsp_valid_o), 32'd1);
      chk("R7 held fields", {6'd0, rsp_status_o, rsp_sr_o, rsp_paddr_o},
          {6'd0, st0, sr0, pa0});
    end
    rsp_ready_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready_i = 1'b0;
    chk("R7 rsp taken", 32'(rsp_valid_o), 32'd0);
    if (wr && est == 2'd0) sm[pg] = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lims [5];
    lims = '{0, 7, 8, 100, 200};
    for (int p = 0; p < 32; p++) begin sv[p] = 0; sf[p] = '0; sm[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid", 32'(rsp_valid_o), 32'd0);
    chk("R1 req_ready", 32'(req_ready_o), 32'd1);
    chk("R1 ld_ready", 32'(ld_ready_o), 32'd0);
    for (int p = 0; p < 32; p++) rd_entry(p, "R1 reset entry");
    do_req(8'h10, 1'b0, 8'hff, 0);

    load_tbl(0, 1'b0);
    for (int p = 0; p < 32; p++) rd_entry(p, "R8 readback pattern A");

    for (int a = 0; a < 256; a++) do_req(8'(a), 1'b0, 8'hff, a % 3);
    for (int p = 0; p < 32; p++) rd_entry(p, "R6 reads keep modify");

    foreach (lims[i]) begin
      if (lims[i] > 0) do_req(8'(lims[i] - 1), 1'b0, 8'(lims[i]), 0);
      do_req(8'(lims[i]), 1'b0, 8'(lims[i]), 0);
      do_req(8'(lims[i] + 1), 1'b0, 8'(lims[i]), 0);
      do_req(8'hff, 1'b1, 8'(lims[i]), 0);
    end

    do_req(8'h0a, 1'b1, 8'hff, 0);
    rd_entry(1, "R6 write hit sets modify");
    do_req(8'h13, 1'b0, 8'hff, 0);
    rd_entry(2, "R6 read hit keeps modify");
    do_req(8'h1c, 1'b1, 8'hff, 0);
    rd_entry(3, "R6 fault write keeps modify");
    do_req(8'h20, 1'b1, 8'h08, 1);
    rd_entry(4, "R6 bounds write keeps modify");

    for (int p = 0; p < 32; p++) do_req(8'(p * 8 + (p % 8)), 1'b1, 8'hff, 0);
    for (int p = 0; p < 32; p++) rd_entry(p, "R6 modify after write sweep");

    load_tbl(1, 1'b0);
    for (int p = 0; p < 32; p++) rd_entry(p, "R9 reload replaces entries");
    for (int a = 0; a < 256; a++) do_req(8'(a), 1'b0, 8'hff, (a % 5 == 0) ? 2 : 0);

    load_tbl(0, 1'b1);
    for (int p = 0; p < 32; p++) rd_entry(p, "R2 load with gaps");
    do_req(8'h2d, 1'b0, 8'hff, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule